// File: doc/BRIEF.md
# Packet Framing Checker

This block sits on the receive side of a channelised packet bus, between the word stream that comes off the bus and the per-port packet buffers. Every valid word carries a port address and start and end markers. The block keeps one "packet open" bit for each port. It detects two framing faults. The first is a port that sends data when no packet is open on it. The second is a port that starts a new packet while its previous packet was never closed. The block repairs each fault before the word goes on, so the buffer behind it always sees well-formed packets.

A missing start is repaired by promoting the offending word to a start of packet. A missing end is repaired by raising a close marker alongside the new start word. That marker tells the buffer to end the packet that was left open on that port and to mark it as errored. Each fault also raises a one-cycle error pulse, together with an 8-bit address of the port at fault. When the downstream buffer reports full, an arriving word is discarded and an overflow pulse is raised. A static enable turns the framing checks and repairs off for all ports. All outputs are registered and appear one clock after the input word. The asynchronous active-low reset is released through a two-stage synchroniser.

Top module: `pkt_frame_chk`

## Requirements
- R1: After reset, every output is 0 and every port is closed. The first word on any port without a start marker is therefore reported as a missing start.
- R2: A valid word with `buf_full` low appears on the outputs one clock later. `out_vld` is 1 and `out_data`, `out_port` and `out_eop` equal the inputs. When no fault applies, `out_sop` equals `in_sop` and `out_close` is 0.
- R3: With checks enabled, a word with `in_sop`=0 on a closed port pulses `err_msop` and is forwarded with `out_sop`=1.
- R4: With checks enabled, a word with `in_sop`=1 on an open port pulses `err_meop` and is forwarded with `out_sop`=1 and `out_close`=1. `out_close`=1 means the packet already open on that port ends in error ahead of this word.
- R5: `err_port` equals the port of the faulting word in the cycle of an error pulse, and is 0 when no error pulse is present.
- R6: With `chk_en` low (set only while in reset), no error is ever flagged, `out_sop` equals `in_sop`, and `out_close` stays 0.
- R7: A valid word while `buf_full` is 1 pulses `ovfl` one clock later. It is not forwarded, raises no framing error, and leaves its port's open state unchanged.
- R8: A forwarded word on a port below `NPORTS` leaves that port open if `in_eop`=0 and closed if `in_eop`=1. Ports are tracked independently of each other.
- R9: A word whose port address is `NPORTS` or above is forwarded unchanged, with no check and no state change.
- R10: Error, overflow and valid outputs are single-cycle. A clock with no valid input produces all-zero pulse outputs, and `err_msop` and `err_meop` are never 1 together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Receive system clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| chk_en | input | 1 | Static enable for framing checks and repair |
| in_vld | input | 1 | Input word valid |
| in_port | input | 8 | Port address of the input word |
| in_sop | input | 1 | Start-of-packet marker |
| in_eop | input | 1 | End-of-packet marker |
| in_data | input | DATA_W | Word payload |
| buf_full | input | 1 | Downstream buffer full |
| out_vld | output | 1 | Forwarded word valid |
| out_port | output | 8 | Port address of the forwarded word |
| out_sop | output | 1 | Start marker, repaired |
| out_eop | output | 1 | End marker |
| out_close | output | 1 | Previous packet on this port ends in error |
| out_data | output | DATA_W | Forwarded payload |
| err_msop | output | 1 | Missing-start error pulse |
| err_meop | output | 1 | Missing-end error pulse |
| err_port | output | 8 | Port address qualifying the error pulses |
| ovfl | output | 1 | Overflow pulse, word lost |

## Verification
A framing fault and a buffer overflow can land on the same word: a start on an already open port, or a marker-less word on a closed port, can arrive while the buffer is full. The bench provokes this by sweeping every port, every prior open state and every marker combination with `buf_full` both low and high. With `buf_full` high it expects only the overflow pulse: no forwarded word, no framing flag, and an unchanged port state. The next word on that port is then judged against the untouched state.

// File: rtl/pfc_pkg.sv
package pfc_pkg;
  typedef enum logic [1:0] {
    FR_OK       = 2'd0,
    FR_MISS_SOP = 2'd1,
    FR_MISS_EOP = 2'd2
  } frame_fault_e;
endpackage

// File: rtl/pfc_open_track.sv
module pfc_open_track #(
  parameter int NPORTS = 16,
  localparam int IDX_W = (NPORTS > 1) ? $clog2(NPORTS) : 1
) (
  input  logic             clk,
  input  logic             rst_sync_n,
  input  logic [IDX_W-1:0] idx,
  input  logic             upd,
  input  logic             nxt_open,
  output logic             cur_open
);
  logic [NPORTS-1:0] open_q;

  for (genvar g = 0; g < NPORTS; g++) begin : g_port
    logic wr_en;
    assign wr_en = upd && (32'(idx) == g);
    always_ff @(posedge clk or negedge rst_sync_n) begin
      if (!rst_sync_n)   open_q[g] <= 1'b0;
      else if (wr_en)    open_q[g] <= nxt_open;
    end
  end

  assign cur_open = open_q[idx];
endmodule

// File: rtl/pfc_classify.sv
module pfc_classify
  import pfc_pkg::*;
(
  input  logic         chk_on,
  input  logic         is_open,
  input  logic         sop,
  output frame_fault_e fault,
  output logic         fix_sop,
  output logic         close_prev
);
  always_comb begin
    fault = FR_OK;
    if (chk_on) begin
      if (!is_open && !sop)     fault = FR_MISS_SOP;
      else if (is_open && sop)  fault = FR_MISS_EOP;
    end
    fix_sop    = sop || (fault == FR_MISS_SOP);
    close_prev = (fault == FR_MISS_EOP);
  end
endmodule

// File: rtl/pkt_frame_chk.sv
module pkt_frame_chk
  import pfc_pkg::*;
#(
  parameter int NPORTS = 16,
  parameter int DATA_W = 32,
  localparam int IDX_W = (NPORTS > 1) ? $clog2(NPORTS) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              chk_en,
  input  logic              in_vld,
  input  logic [7:0]        in_port,
  input  logic              in_sop,
  input  logic              in_eop,
  input  logic [DATA_W-1:0] in_data,
  input  logic              buf_full,
  output logic              out_vld,
  output logic [7:0]        out_port,
  output logic              out_sop,
  output logic              out_eop,
  output logic              out_close,
  output logic [DATA_W-1:0] out_data,
  output logic              err_msop,
  output logic              err_meop,
  output logic [7:0]        err_port,
  output logic              ovfl
);
  // reset synchroniser: assert asynchronously, release on clock
  logic [1:0] rst_pipe_q;
  logic       rst_sync_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= 2'b00;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe_q[1];

  logic             in_range;
  logic             accept;
  logic             track_upd;
  logic [IDX_W-1:0] idx;
  logic             cur_open;
  frame_fault_e     fault;
  logic             fix_sop;
  logic             close_prev;

  assign in_range  = (32'(in_port) < NPORTS);
  assign idx       = in_port[IDX_W-1:0];
  assign accept    = in_vld && !buf_full;
  assign track_upd = accept && in_range;

  pfc_open_track #(.NPORTS(NPORTS)) u_track (
    .clk        (clk),
    .rst_sync_n (rst_sync_n),
    .idx        (idx),
    .upd        (track_upd),
    .nxt_open   (!in_eop),
    .cur_open   (cur_open)
  );

  pfc_classify u_class (
    .chk_on     (chk_en && in_range),
    .is_open    (cur_open),
    .sop        (in_sop),
    .fault      (fault),
    .fix_sop    (fix_sop),
    .close_prev (close_prev)
  );

  // next-state
  logic              vld_d, sop_d, eop_d, close_d, msop_d, meop_d, ovfl_d;
  logic [7:0]        port_d, eport_d;
  logic [DATA_W-1:0] data_d;

  always_comb begin
    vld_d   = accept;
    ovfl_d  = in_vld && buf_full;
    port_d  = accept ? in_port : 8'd0;
    data_d  = accept ? in_data : '0;
    eop_d   = accept && in_eop;
    sop_d   = accept && fix_sop;
    close_d = accept && close_prev;
    msop_d  = accept && (fault == FR_MISS_SOP);
    meop_d  = accept && (fault == FR_MISS_EOP);
    eport_d = (msop_d || meop_d) ? in_port : 8'd0;
  end

  // registers
  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      out_vld   <= 1'b0;
      out_port  <= 8'd0;
      out_sop   <= 1'b0;
      out_eop   <= 1'b0;
      out_close <= 1'b0;
      out_data  <= '0;
      err_msop  <= 1'b0;
      err_meop  <= 1'b0;
      err_port  <= 8'd0;
      ovfl      <= 1'b0;
    end else begin
      out_vld   <= vld_d;
      out_port  <= port_d;
      out_sop   <= sop_d;
      out_eop   <= eop_d;
      out_close <= close_d;
      out_data  <= data_d;
      err_msop  <= msop_d;
      err_meop  <= meop_d;
      err_port  <= eport_d;
      ovfl      <= ovfl_d;
    end
  end
endmodule

// File: rtl/pkt_frame_chk_sva.sv
module pkt_frame_chk_sva #(
  parameter int NPORTS = 16
) (
  input logic       clk,
  input logic       rst_sync_n,
  input logic       chk_en,
  input logic       in_vld,
  input logic [7:0] in_port,
  input logic       buf_full,
  input logic       out_vld,
  input logic [7:0] out_port,
  input logic       out_sop,
  input logic       out_close,
  input logic       err_msop,
  input logic       err_meop,
  input logic [7:0] err_port,
  input logic       ovfl
);
  AST_PASS_LATENCY: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (in_vld && !buf_full) |=> (out_vld && !ovfl)); // R2
  AST_MSOP_REPAIR: assert property (@(posedge clk) disable iff (!rst_sync_n)
    err_msop |-> (out_vld && out_sop && !out_close)); // R3
  AST_MEOP_REPAIR: assert property (@(posedge clk) disable iff (!rst_sync_n)
    err_meop |-> (out_vld && out_sop && out_close)); // R4
  AST_ERR_QUALIFIER: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (err_msop || err_meop) |-> (err_port == out_port)); // R5
  AST_DISABLED_QUIET: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !chk_en |-> !(err_msop || err_meop || out_close)); // R6
  AST_NO_OVERFLOW_FWD: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (in_vld && buf_full) |=> (ovfl && !out_vld && !err_msop && !err_meop)); // R7
  AST_RANGE_UNCHECKED: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (in_vld && !buf_full && (32'(in_port) >= NPORTS)) |=> !(err_msop || err_meop || out_close)); // R9
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !in_vld |=> !(out_vld || ovfl || err_msop || err_meop)); // R10
  AST_FLAGS_EXCL: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !(err_msop && err_meop)); // R10
endmodule

bind pkt_frame_chk pkt_frame_chk_sva #(.NPORTS(NPORTS)) u_sva (
  .clk        (clk),
  .rst_sync_n (rst_sync_n),
  .chk_en     (chk_en),
  .in_vld     (in_vld),
  .in_port    (in_port),
  .buf_full   (buf_full),
  .out_vld    (out_vld),
  .out_port   (out_port),
  .out_sop    (out_sop),
  .out_close  (out_close),
  .err_msop   (err_msop),
  .err_meop   (err_meop),
  .err_port   (err_port),
  .ovfl       (ovfl)
);

// File: tb/pkt_frame_chk_test.sv
module pkt_frame_chk_test;
  localparam int NP = 4;
  localparam int DW = 8;

  logic          clk = 1'b0;
  logic          rst_n, chk_en, in_vld, in_sop, in_eop, buf_full;
  logic [7:0]    in_port;
  logic [DW-1:0] in_data;
  logic          out_vld, out_sop, out_eop, out_close, err_msop, err_meop, ovfl;
  logic [7:0]    out_port, err_port;
  logic [DW-1:0] out_data;

  int checks = 0;
  int errors = 0;
  bit model_open [NP];
  bit en_model;
  logic [DW-1:0] seq = '0;

  always #4 clk = ~clk;

  pkt_frame_chk #(.NPORTS(NP), .DATA_W(DW)) uut (
    .clk(clk), .rst_n(rst_n), .chk_en(chk_en), .in_vld(in_vld),
    .in_port(in_port), .in_sop(in_sop), .in_eop(in_eop), .in_data(in_data),
    .buf_full(buf_full), .out_vld(out_vld), .out_port(out_port),
    .out_sop(out_sop), .out_eop(out_eop), .out_close(out_close),
    .out_data(out_data), .err_msop(err_msop), .err_meop(err_meop),
    .err_port(err_port), .ovfl(ovfl)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic chk_idle(input string req);
    chk(!out_vld, req, "out_vld", int'(out_vld), 0);
    chk(!ovfl, req, "ovfl", int'(ovfl), 0);
    chk(!err_msop && !err_meop, req, "err flags", int'({err_msop, err_meop}), 0);
    chk(err_port == 8'd0, req, "err_port", int'(err_port), 0);
  endtask

  task automatic do_reset(input bit en);
    in_vld = 0; in_sop = 0; in_eop = 0; buf_full = 0; in_port = 0; in_data = 0;
    rst_n = 0; chk_en = en; en_model = en;
    foreach (model_open[i]) model_open[i] = 0;
    repeat (3) @(negedge clk);
    chk_idle("R1");
    chk(!out_sop && !out_close && out_port == 0, "R1", "reset outputs",
        int'({out_sop, out_close}), 0);
    rst_n = 1;
    repeat (3) @(negedge clk);
  endtask

  // called at a negedge: drives one word, checks the registered result at the next negedge
  task automatic send(input int p, input bit s, input bit e, input bit f);
    bit inr, msop, meop, xsop, xclose;
    inr = p < NP;
    msop = 0; meop = 0;
    if (inr && en_model && !f) begin
      msop = !model_open[p] && !s;
      meop = model_open[p] && s;
    end
    xsop = s || msop;
    xclose = meop;
    seq = seq + 8'd37;
    in_vld = 1; in_port = 8'(p); in_sop = s; in_eop = e; buf_full = f; in_data = seq;
    @(negedge clk);
    in_vld = 0; in_sop = 0; in_eop = 0; buf_full = 0;
    if (f) begin
      chk(ovfl, "R7", "ovfl", int'(ovfl), 1);
      chk(!out_vld, "R7", "dropped word forwarded", int'(out_vld), 0);
      chk(!err_msop && !err_meop, "R7", "framing flag on dropped word",
          int'({err_msop, err_meop}), 0);
    end else begin
      chk(out_vld && !ovfl, "R2", "out_vld/ovfl", int'({out_vld, ovfl}), 2);
      chk(out_data == seq && out_port == 8'(p) && out_eop == e, "R2", "data/port/eop",
          int'(out_data), int'(seq));
      chk(err_msop == msop, inr ? "R3" : "R9", "err_msop", int'(err_msop), int'(msop));
      chk(err_meop == meop, inr ? "R4" : "R9", "err_meop", int'(err_meop), int'(meop));
      chk(out_sop == xsop, en_model ? "R3" : "R6", "out_sop", int'(out_sop), int'(xsop));
      chk(out_close == xclose, en_model ? "R4" : "R6", "out_close",
          int'(out_close), int'(xclose));
      chk(err_port == ((msop || meop) ? 8'(p) : 8'd0), "R5", "err_port",
          int'(err_port), (msop || meop) ? p : 0);
      if (inr) model_open[p] = !e;   // R8
    end
    @(negedge clk);
    chk_idle("R10");
  endtask

  task automatic sweep();
    int ports [6] = '{0, 1, 2, 3, 4, 200};
    foreach (ports[k]) begin
      for (int st = 0; st < 2; st++)
        for (int se = 0; se < 4; se++)
          for (int f = 0; f < 2; f++) begin
            int p = ports[k];
            if (p < NP && model_open[p] != bit'(st)) begin
              if (st == 1) send(p, 1, 0, 0);
              else send(p, 0, 1, 0);
            end
            send(p, se[1], se[0], f[0]);
          end
    end
  endtask

  initial begin
    fork
      begin
        do_reset(1'b1);
        // R1: first marker-less word after reset reports missing start
        send(0, 0, 0, 0);
        // R8: interleaved ports keep independent state
        send(1, 1, 0, 0);
        send(2, 1, 0, 0);
        send(1, 0, 0, 0);
        send(2, 0, 1, 0);
        send(1, 1, 0, 0);
        send(2, 0, 0, 0);
        sweep();
        do_reset(1'b0);
        sweep();
      end
      begin
        repeat (100000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    disable fork;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule